// File: doc/BRIEF.md
# Programmable Multi-Mode Position Counter

This block keeps a position count that moves one step per qualified count pulse, in the direction given by a direction bit. Software-visible state sits in five registers: the count, a limit/compare value, a snapshot copy of the count, and two mode bytes. Every change to that state arrives as a single-cycle strobe. The first mode byte selects the counting discipline and what an index event does. The second mode byte selects the active width of one to four bytes, a software count inhibit, and which events may drive the two flag pins.

Four disciplines are available: free-running wrap, one-shot (single-cycle), clamped range and divide-by-(n+1). The one-shot discipline is held by a two-state run controller. In state `RS_RUN`, count pulses are applied. When a pulse produces a carry or borrow in one-shot mode, the transition *halt-on-wrap* moves the controller to `RS_HALT`, where pulses are ignored. A counter clear or a counter load, from a strobe or from an index event, takes the transition *resume-on-clear/load* back to `RS_RUN`.

Carry, borrow, compare and index events are held in a status byte until software clears it. They drive an active-low latched flag and an active-low one-cycle pulsed flag, both gated by per-event enables.

Top module: `pos_counter`

## Requirements
- R1: After reset, the count, the snapshot and both mode bytes are zero. The status byte reads 8'h0C while `cnt_en_in` is high: the power-loss bit [2] and the live enable bit [3] are set, all else is 0. Both flag outputs are high.
- R2: Mode byte A bits [3:2] select the discipline: 00 free, 01 one-shot, 10 range, 11 modulo. In free mode an up pulse at the all-ones value of the active width wraps to 0 and sets carry (status bit 7). A down pulse at 0 wraps to all ones and sets borrow (status bit 6).
- R3: Mode byte B bits [1:0] select the active width: 00 = 4 bytes, 01 = 3, 10 = 2, 11 = 1. The count, the loaded value and the compare all use that width, so carry and borrow occur at its boundary.
- R4: In one-shot mode the counter wraps as in free mode and then ignores pulses. It resumes only after a counter clear or a counter load. While halted, status bit 3 reads 0.
- R5: In range mode an up pulse at the limit value holds the count and sets carry. A down pulse at 0 holds the count and sets borrow. A pulse in the opposite direction moves the count again.
- R6: In modulo mode an up pulse at the limit value n goes to 0 with carry. A down pulse at 0 goes to n with borrow.
- R7: Mode byte A bits [5:4] select the index action: 00 none, 01 load the count from the limit, 10 clear the count, 11 copy the count to the snapshot. Every index event sets status bit 4.
- R8: A pulse is applied only when `cnt_en_in` is high and mode byte B bit 2 is 0. Status bit 3 shows whether pulses are accepted.
- R9: Any register strobe, or an index event with an action, blocks a count pulse in the same cycle. If both a clear and a load of the count arrive together, the clear wins.
- R10: Status bit 5 latches when a pulse makes the count equal the limit. Bit 1 holds the direction of the last applied pulse (1 = up). Bit 0 is the top bit of the active width.
- R11: `lflag_n` is low while any enabled latched event is set. Mode byte B bits [7:4] enable carry, borrow, compare and index. The pin stays low until the status clear strobe, which also clears the power-loss bit.
- R12: `dflag_n` goes low for exactly one cycle after each cycle in which an enabled event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pulse | input | 1 | One count step request this cycle |
| cnt_up | input | 1 | Step direction, 1 = up |
| cnt_en_in | input | 1 | External count enable |
| index_evt | input | 1 | Index event this cycle |
| op_clr_cntr | input | 1 | Clear the count |
| op_load_cntr | input | 1 | Load the count from the limit register |
| op_snap | input | 1 | Copy the count to the snapshot register |
| op_clr_status | input | 1 | Clear the status latches |
| wr_limit | input | 1 | Write `wr_value` to the limit register |
| wr_mode_a | input | 1 | Write `wr_value[7:0]` to mode byte A |
| wr_mode_b | input | 1 | Write `wr_value[7:0]` to mode byte B |
| wr_value | input | 32 | Write data |
| count_q | output | 32 | Count, masked to the active width |
| snap_q | output | 32 | Snapshot register |
| status_q | output | 8 | Status byte |
| lflag_n | output | 1 | Latched event flag, active low |
| dflag_n | output | 1 | Pulsed event flag, active low |

## Verification
The assertions check the following on every cycle:
- a count clear beats any pulse;
- a halted one-shot counter holds;
- modulo wrap and range freeze occur at the limit;
- a gated-off pulse leaves the count alone;
- the latched flag holds until cleared;
- a pulsed flag always coincides with a latched one.

The wrap values at each of the four widths, the exact status encodings, the index actions, and the sequence of a one-shot halt and its resume can only be shown by the bench's scenarios.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
    typedef enum logic [1:0] {
        CM_FREE   = 2'b00,
        CM_SINGLE = 2'b01,
        CM_RANGE  = 2'b10,
        CM_MODULO = 2'b11
    } count_mode_e;

    typedef enum logic [1:0] {
        IX_OFF   = 2'b00,
        IX_LOAD  = 2'b01,
        IX_CLEAR = 2'b10,
        IX_SNAP  = 2'b11
    } index_fn_e;

    typedef enum logic {
        RS_RUN  = 1'b0,
        RS_HALT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic carry;
        logic borrow;
        logic match;
    } step_ev_t;
endpackage

// File: rtl/pcnt_step.sv
module pcnt_step
    import pcnt_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int W = 8 * BYTES
) (
    input  logic [1:0]   width_sel,
    input  count_mode_e  mode,
    input  logic         up,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cur_m,
    output logic [W-1:0] lim_m,
    output logic [W-1:0] nxt,
    output step_ev_t     ev,
    output logic         sign
);
    localparam logic [W-1:0] ONE = W'(1);

    int         act;
    logic [W-1:0] mask;
    logic [W-1:0] topm;

    always_comb begin
        act = BYTES - int'(width_sel);
        if (act < 1) act = 1;
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        assign mask[8*b +: 8] = (b < act) ? 8'hFF : 8'h00;
        assign topm[8*b +: 8] = (b == act - 1) ? 8'h80 : 8'h00;
    end

    assign cur_m = cur & mask;
    assign lim_m = limit & mask;
    assign sign  = |(cur_m & topm);

    always_comb begin
        nxt       = cur_m;
        ev.carry  = 1'b0;
        ev.borrow = 1'b0;
        if (up) begin
            unique case (mode)
                CM_RANGE: begin
                    if (cur_m == lim_m) ev.carry = 1'b1;
                    else                nxt = (cur_m + ONE) & mask;
                end
                CM_MODULO: begin
                    if (cur_m == lim_m) begin
                        nxt = '0;
                        ev.carry = 1'b1;
                    end else nxt = (cur_m + ONE) & mask;
                end
                CM_FREE, CM_SINGLE: begin
                    if (cur_m == mask) begin
                        nxt = '0;
                        ev.carry = 1'b1;
                    end else nxt = (cur_m + ONE) & mask;
                end
            endcase
        end else begin
            unique case (mode)
                CM_RANGE: begin
                    if (cur_m == '0) ev.borrow = 1'b1;
                    else             nxt = (cur_m - ONE) & mask;
                end
                CM_MODULO: begin
                    if (cur_m == '0) begin
                        nxt = lim_m;
                        ev.borrow = 1'b1;
                    end else nxt = (cur_m - ONE) & mask;
                end
                CM_FREE, CM_SINGLE: begin
                    if (cur_m == '0) begin
                        nxt = mask;
                        ev.borrow = 1'b1;
                    end else nxt = (cur_m - ONE) & mask;
                end
            endcase
        end
        ev.match = (nxt == lim_m);
    end
endmodule

// File: rtl/pcnt_flags.sv
module pcnt_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_cy,
    input  logic       ev_bw,
    input  logic       ev_cmp,
    input  logic       ev_idx,
    input  logic       clr_latch,
    input  logic [3:0] flag_en,
    output logic [3:0] lat,
    output logic       pls,
    output logic       lflag_n,
    output logic       dflag_n
);
    logic [3:0] ev_now;
    assign ev_now = {ev_cy, ev_bw, ev_cmp, ev_idx};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat     <= '0;
            pls     <= 1'b1;
            dflag_n <= 1'b1;
        end else begin
            lat     <= (clr_latch ? 4'b0 : lat) | ev_now;
            if (clr_latch) pls <= 1'b0;
            dflag_n <= ~|(ev_now & flag_en);
        end
    end

    assign lflag_n = ~|(lat & flag_en);

    // R11: latched flag holds until status clear or enable change
    p_lflag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!lflag_n && !clr_latch) |=> (!lflag_n || !$stable(flag_en)));

    // R12: a pulsed flag is always backed by a latched event
    p_dflag_latched_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflag_n && $stable(flag_en)) |-> !lflag_n);
endmodule

// File: rtl/pos_counter.sv
module pos_counter
    import pcnt_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int W = 8 * BYTES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_pulse,
    input  logic         cnt_up,
    input  logic         cnt_en_in,
    input  logic         index_evt,
    input  logic         op_clr_cntr,
    input  logic         op_load_cntr,
    input  logic         op_snap,
    input  logic         op_clr_status,
    input  logic         wr_limit,
    input  logic         wr_mode_a,
    input  logic         wr_mode_b,
    input  logic [W-1:0] wr_value,
    output logic [W-1:0] count_q,
    output logic [W-1:0] snap_q,
    output logic [7:0]   status_q,
    output logic         lflag_n,
    output logic         dflag_n
);
    logic [7:0]   mode_a, mode_b;
    logic [W-1:0] limit_r, cnt_r;
    logic         dir_r;
    run_state_e   state, state_nx;

    count_mode_e  cmode;
    index_fn_e    ixfn;
    logic [W-1:0] cur_m, lim_m, nxt;
    step_ev_t     ev;
    logic         sign;
    logic         ix_load, ix_clear, ix_snap;
    logic         do_clear, do_load, do_snap, any_op, count_ok, step_go;
    logic [3:0]   lat;
    logic         pls;

    assign cmode = count_mode_e'(mode_a[3:2]);
    assign ixfn  = index_fn_e'(mode_a[5:4]);

    pcnt_step #(.BYTES(BYTES)) u_step (
        .width_sel (mode_b[1:0]),
        .mode      (cmode),
        .up        (cnt_up),
        .cur       (cnt_r),
        .limit     (limit_r),
        .cur_m     (cur_m),
        .lim_m     (lim_m),
        .nxt       (nxt),
        .ev        (ev),
        .sign      (sign)
    );

    assign ix_load  = index_evt && (ixfn == IX_LOAD);
    assign ix_clear = index_evt && (ixfn == IX_CLEAR);
    assign ix_snap  = index_evt && (ixfn == IX_SNAP);
    assign do_clear = op_clr_cntr | ix_clear;
    assign do_load  = (op_load_cntr | ix_load) & ~do_clear;
    assign do_snap  = op_snap | ix_snap;
    assign any_op   = op_clr_cntr | op_load_cntr | op_snap | op_clr_status |
                      wr_limit | wr_mode_a | wr_mode_b |
                      (index_evt && (ixfn != IX_OFF));
    assign count_ok = cnt_en_in && !mode_b[2] && (state == RS_RUN);
    assign step_go  = cnt_pulse && count_ok && !any_op;

    // run controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_RUN;
        else        state <= state_nx;
    end

    // run controller: transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            RS_RUN:  if (step_go && cmode == CM_SINGLE && (ev.carry || ev.borrow))
                         state_nx = RS_HALT;
            RS_HALT: if (do_clear || do_load)
                         state_nx = RS_RUN;
        endcase
    end

    // register file and counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_a  <= '0;
            mode_b  <= '0;
            limit_r <= '0;
            cnt_r   <= '0;
            snap_q  <= '0;
            dir_r   <= 1'b0;
        end else begin
            if (wr_mode_a) mode_a  <= wr_value[7:0];
            if (wr_mode_b) mode_b  <= wr_value[7:0];
            if (wr_limit)  limit_r <= wr_value;
            if (do_snap)   snap_q  <= cur_m;
            if (do_clear)     cnt_r <= '0;
            else if (do_load) cnt_r <= lim_m;
            else if (step_go) cnt_r <= nxt;
            if (step_go) dir_r <= cnt_up;
        end
    end

    pcnt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_cy     (step_go & ev.carry),
        .ev_bw     (step_go & ev.borrow),
        .ev_cmp    (step_go & ev.match),
        .ev_idx    (index_evt),
        .clr_latch (op_clr_status),
        .flag_en   (mode_b[7:4]),
        .lat       (lat),
        .pls       (pls),
        .lflag_n   (lflag_n),
        .dflag_n   (dflag_n)
    );

    assign count_q  = cur_m;
    assign status_q = {lat, count_ok, pls, dir_r, sign};

    // R9: clear strobe beats everything
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_clr_cntr |=> (cnt_r == '0));

    // R4: halted one-shot counter holds without clear or load
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_HALT && !do_clear && !do_load) |=> $stable(cnt_r));

    // R6: modulo up step at limit returns to zero
    p_modulo_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && cmode == CM_MODULO && cnt_up && cur_m == lim_m) |=> (cnt_r == '0));

    // R5: range up step at limit freezes
    p_range_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && cmode == CM_RANGE && cnt_up && cur_m == lim_m) |=> $stable(cnt_r));

    // R8: gated-off pulse leaves count untouched
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_in && !do_clear && !do_load) |=> $stable(cnt_r));
endmodule

// File: tb/pos_counter_test.sv
module pos_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_pulse = 0, cnt_up = 0, cnt_en_in = 1, index_evt = 0;
    logic        op_clr_cntr = 0, op_load_cntr = 0, op_snap = 0, op_clr_status = 0;
    logic        wr_limit = 0, wr_mode_a = 0, wr_mode_b = 0;
    logic [31:0] wr_value = '0;
    logic [31:0] count_q, snap_q;
    logic [7:0]  status_q;
    logic        lflag_n, dflag_n;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    pos_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
        .cnt_en_in(cnt_en_in), .index_evt(index_evt), .op_clr_cntr(op_clr_cntr),
        .op_load_cntr(op_load_cntr), .op_snap(op_snap), .op_clr_status(op_clr_status),
        .wr_limit(wr_limit), .wr_mode_a(wr_mode_a), .wr_mode_b(wr_mode_b),
        .wr_value(wr_value), .count_q(count_q), .snap_q(snap_q),
        .status_q(status_q), .lflag_n(lflag_n), .dflag_n(dflag_n)
    );

    typedef struct packed {
        logic [7:0]  ma;
        logic [7:0]  mb;
        logic [31:0] lim;
        logic [31:0] start;
        logic        up;
        logic [31:0] exp;
        logic [1:0]  ev;   // {carry, borrow}
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{8'h00, 8'h00, 32'h0, 32'hFFFFFFFF, 1'b1, 32'h00000000, 2'b10},
        '{8'h00, 8'h00, 32'h0, 32'h00000000, 1'b0, 32'hFFFFFFFF, 2'b01},
        '{8'h00, 8'h03, 32'h0, 32'h000000FF, 1'b1, 32'h00000000, 2'b10},
        '{8'h00, 8'h02, 32'h0, 32'h0000FFFF, 1'b1, 32'h00000000, 2'b10},
        '{8'h00, 8'h01, 32'h0, 32'h00000000, 1'b0, 32'h00FFFFFF, 2'b01},
        '{8'h00, 8'h00, 32'h0, 32'h00000005, 1'b1, 32'h00000006, 2'b00},
        '{8'h08, 8'h00, 32'h5, 32'h00000005, 1'b1, 32'h00000005, 2'b10},
        '{8'h08, 8'h00, 32'h5, 32'h00000000, 1'b0, 32'h00000000, 2'b01},
        '{8'h08, 8'h00, 32'h5, 32'h00000003, 1'b1, 32'h00000004, 2'b00},
        '{8'h0C, 8'h00, 32'h9, 32'h00000009, 1'b1, 32'h00000000, 2'b10},
        '{8'h0C, 8'h00, 32'h9, 32'h00000000, 1'b0, 32'h00000009, 2'b01},
        '{8'h0C, 8'h00, 32'h9, 32'h00000004, 1'b1, 32'h00000005, 2'b00}
    };

    task automatic tick;
        @(negedge clk);
        {cnt_pulse, index_evt, op_clr_cntr, op_load_cntr, op_snap, op_clr_status,
         wr_limit, wr_mode_a, wr_mode_b} = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_a(input logic [7:0] v);
        wr_value = {24'h0, v}; wr_mode_a = 1; tick;
    endtask
    task automatic set_b(input logic [7:0] v);
        wr_value = {24'h0, v}; wr_mode_b = 1; tick;
    endtask
    task automatic set_lim(input logic [31:0] v);
        wr_value = v; wr_limit = 1; tick;
    endtask
    task automatic load_cnt(input logic [31:0] v);
        set_lim(v); op_load_cntr = 1; tick;
    endtask
    task automatic step(input logic up);
        cnt_up = up; cnt_pulse = 1; tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick;
        // R1 reset state
        chk("R1 count", count_q, 32'h0);
        chk("R1 snap", snap_q, 32'h0);
        chk("R1 status", {24'h0, status_q}, 32'h0C);
        chk("R1 flags", {30'h0, lflag_n, dflag_n}, 32'h3);

        // table walk: R2 R3 R5 R6
        for (int i = 0; i < 12; i++) begin
            string tag;
            if (VECS[i].ma[3:2] == 2'b10)      tag = "R5";
            else if (VECS[i].ma[3:2] == 2'b11) tag = "R6";
            else if (VECS[i].mb != 8'h00)      tag = "R3";
            else                               tag = "R2";
            set_a(VECS[i].ma);
            set_b(VECS[i].mb);
            load_cnt(VECS[i].start);
            set_lim(VECS[i].lim);
            op_clr_status = 1; tick;
            step(VECS[i].up);
            chk({tag, " count"}, count_q, VECS[i].exp);
            chk({tag, " cy/bw"}, {30'h0, status_q[7:6]}, {30'h0, VECS[i].ev});
        end

        // R4 one-shot halt and resume
        set_a(8'h04); set_b(8'h03);
        load_cnt(32'hFE);
        step(1'b1);
        chk("R4 pre-wrap", count_q, 32'hFF);
        step(1'b1);
        chk("R4 wrap", count_q, 32'h00);
        chk("R4 halted enable bit", {31'h0, status_q[3]}, 32'h0);
        step(1'b1);
        chk("R4 ignored", count_q, 32'h00);
        load_cnt(32'h07);
        step(1'b1);
        chk("R4 resumed", count_q, 32'h08);

        // R7 index actions
        set_a(8'h10); set_b(8'h00);
        op_clr_status = 1; tick;
        set_lim(32'h33);
        index_evt = 1; tick;
        chk("R7 index load", count_q, 32'h33);
        chk("R7 index latch", {31'h0, status_q[4]}, 32'h1);
        set_a(8'h20);
        index_evt = 1; tick;
        chk("R7 index clear", count_q, 32'h0);
        step(1'b1);
        set_a(8'h30);
        index_evt = 1; tick;
        chk("R7 index snapshot", snap_q, 32'h1);
        set_a(8'h00);
        index_evt = 1; tick;
        chk("R7 index none", count_q, 32'h1);

        // R8 enable gating
        cnt_en_in = 0; tick;
        step(1'b1);
        chk("R8 pin gate", count_q, 32'h1);
        chk("R8 enable bit low", {31'h0, status_q[3]}, 32'h0);
        cnt_en_in = 1;
        set_b(8'h04);
        step(1'b1);
        chk("R8 mode gate", count_q, 32'h1);
        set_b(8'h00);
        step(1'b1);
        chk("R8 reenabled", count_q, 32'h2);

        // R9 priority
        cnt_pulse = 1; cnt_up = 1; op_clr_cntr = 1; tick;
        chk("R9 clear over pulse", count_q, 32'h0);
        set_lim(32'h33);
        cnt_pulse = 1; op_load_cntr = 1; tick;
        chk("R9 load over pulse", count_q, 32'h33);
        op_clr_cntr = 1; op_load_cntr = 1; tick;
        chk("R9 clear over load", count_q, 32'h0);

        // R10 compare, direction, sign
        set_b(8'h03);
        load_cnt(32'h7F);
        set_lim(32'h80);
        op_clr_status = 1; tick;
        step(1'b1);
        chk("R10 up to limit", {24'h0, status_q}, 32'h2B);
        step(1'b0);
        chk("R10 down", {24'h0, status_q}, 32'h28);

        // R11 latched flag, R12 pulsed flag
        set_b(8'h80); set_a(8'h00);
        load_cnt(32'hFFFFFFFF);
        op_clr_status = 1; tick;
        chk("R11 idle", {31'h0, lflag_n}, 32'h1);
        step(1'b1);
        chk("R11 set", {31'h0, lflag_n}, 32'h0);
        chk("R12 pulse low", {31'h0, dflag_n}, 32'h0);
        tick;
        chk("R12 pulse ends", {31'h0, dflag_n}, 32'h1);
        tick;
        chk("R11 held", {31'h0, lflag_n}, 32'h0);
        op_clr_status = 1; tick;
        chk("R11 cleared", {31'h0, lflag_n}, 32'h1);
        chk("R11 power-loss cleared", {31'h0, status_q[2]}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule